// File: doc/BRIEF.md
# Constant-On-Time Gate Pulse Sequencer

This block sequences the upper (high-side) and lower (low-side) gate enables of one buck converter phase under constant-on-time control. The analog front end supplies three one-bit flags: the error comparator saying the output is low, an over-current flag for the low-side switch, and a zero-crossing flag for the inductor current. The block turns these into gate commands. Every timing is counted in clock cycles: the on-pulse length comes from a programmed count, raised to a minimum width when needed. A minimum off-time and a non-overlap dead-time are derived from nanosecond parameters and the clock period.

Two conduction modes exist. In forced-PWM mode the zero-crossing flag is ignored and the lower gate fills every gap between on-pulses, apart from the dead-times. In pulse-skipping mode the lower gate is cut as soon as the inductor current crosses zero, and both gates then rest until the next accepted trigger. A single force-off input, used for fault shutdown, and the enable input both drop the two gates at once and return the sequencer to idle.

Top module: `cot_gate_seq`

## Requirements
- R1: While rst_n is low, and after its release until a trigger is accepted, hs_en and ls_en are both 0.
- R2: A trigger is accepted at a clock edge only if en=1, force_off=0, cmp_hit=1, oc_hit=0, the sequencer is idle or in low-side conduction, and the minimum off-time has run out. hs_en rises exactly DT cycles after the accepting edge (DT = ceil(DT_NS/CLK_NS), 3 by default).
- R3: Each on-pulse lasts max(ton_cyc, MIN_ON) cycles (MIN_ON = ceil(MIN_ON_NS/CLK_NS), 11 by default). ton_cyc is sampled at the accepting edge, and later changes to it do not alter the running pulse.
- R4: Between two on-pulses, hs_en stays low for at least MIN_OFF+DT cycles (MIN_OFF = ceil(MIN_OFF_NS/CLK_NS), 30 by default). The gap is exactly MIN_OFF+DT when cmp_hit=1 and oc_hit=0 are held throughout.
- R5: ls_en rises no earlier than DT cycles after hs_en falls. hs_en rises no earlier than DT cycles after ls_en falls. The two are never 1 together.
- R6: With mode_skip=0 (forced PWM), zc_hit has no effect. ls_en turns on exactly DT cycles after the on-pulse ends and stays on until the next accepted trigger, except while oc_hit=1.
- R7: With mode_skip=1 (pulse skipping), ls_en is 0 in any cycle where zc_hit=1. Once zc_hit is seen after an on-pulse ends, both gates stay 0 until the next on-pulse.
- R8: ls_en is 0 in every cycle where oc_hit=1, and no trigger is accepted while oc_hit=1.
- R9: force_off=1 or en=0 drives hs_en and ls_en to 0 in the same cycle and returns the sequencer to idle with the off-time cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sequencer enable |
| force_off | input | 1 | Fault shutdown: both gates off at once |
| mode_skip | input | 1 | 1 = pulse skipping, 0 = forced PWM |
| cmp_hit | input | 1 | Error comparator: output below target |
| oc_hit | input | 1 | Low-side current above limit |
| zc_hit | input | 1 | Inductor current zero crossing |
| ton_cyc | input | TON_W | Programmed on-time in clock cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The assertions assume mode_skip changes only while force_off or en holds the sequencer idle. They also assume reset is held for a few cycles, so the pulse and gap counters start from a known state. The stimulus changes mode only inside force_off windows and otherwise holds each input for at least one full cycle. The random phase toggles the comparator, over-current and zero-crossing flags independently and draws on-time values both below and above the minimum width.

// File: rtl/cot_seq_pkg.sv
`timescale 1ns/1ps
package cot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // both gates off, waiting for a trigger
    ST_LEAD = 3'd1,  // dead-time before the high side turns on
    ST_ON   = 3'd2,  // high-side on-pulse
    ST_TAIL = 3'd3,  // dead-time before the low side turns on
    ST_LOW  = 3'd4   // low-side conduction
  } seq_state_t;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cot_off_timer.sv
`timescale 1ns/1ps
module cot_off_timer #(
  parameter int unsigned W    = 5,
  parameter int unsigned LOAD = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic done
);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (start)          cnt_q <= LOAD_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/cot_fire_qual.sv
`timescale 1ns/1ps
module cot_fire_qual
  import cot_seq_pkg::*;
(
  input  logic       run,
  input  logic       cmp_hit,
  input  logic       oc_hit,
  input  logic       off_done,
  input  seq_state_t state,
  output logic       fire
);
  logic resting;
  assign resting = (state == ST_IDLE) || (state == ST_LOW);
  assign fire    = run && cmp_hit && !oc_hit && off_done && resting;
endmodule

// File: rtl/cot_gate_drive.sv
`timescale 1ns/1ps
module cot_gate_drive
  import cot_seq_pkg::*;
(
  input  logic       run,
  input  seq_state_t state,
  input  logic       skip,
  input  logic       oc_hit,
  input  logic       zc_hit,
  output logic       hs_en,
  output logic       ls_en
);
  logic zc_cut;
  assign zc_cut = skip && zc_hit;
  assign hs_en  = run && (state == ST_ON);
  assign ls_en  = run && (state == ST_LOW) && !oc_hit && !zc_cut;
endmodule

// File: rtl/cot_gate_seq.sv
`timescale 1ns/1ps
module cot_gate_seq #(
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned TON_W      = 8,
  parameter int unsigned DT_NS      = 30,
  parameter int unsigned MIN_ON_NS  = 110,
  parameter int unsigned MIN_OFF_NS = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             force_off,
  input  logic             mode_skip,
  input  logic             cmp_hit,
  input  logic             oc_hit,
  input  logic             zc_hit,
  input  logic [TON_W-1:0] ton_cyc,
  output logic             hs_en,
  output logic             ls_en
);
  import cot_seq_pkg::*;

  localparam int unsigned DT_CYC      = ns_to_cyc(DT_NS, CLK_NS);
  localparam int unsigned MIN_ON_CYC  = ns_to_cyc(MIN_ON_NS, CLK_NS);
  localparam int unsigned MIN_OFF_CYC = ns_to_cyc(MIN_OFF_NS, CLK_NS);
  localparam int unsigned CNT_W =
    umax(TON_W, umax($clog2(MIN_ON_CYC + 1), $clog2(DT_CYC + 1)));
  localparam int unsigned OFF_W  = $clog2(MIN_OFF_CYC + 1);
  localparam logic [CNT_W-1:0] DT_LOAD  = CNT_W'(DT_CYC - 1);
  localparam logic [CNT_W-1:0] MIN_ON_V = CNT_W'(MIN_ON_CYC);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] ton_ext, ton_clamped;
  logic             run, fire, off_done, off_start, zc_cut;

  assign run       = en && !force_off;
  assign zc_cut    = mode_skip && zc_hit;
  assign off_start = run && (st_q == ST_ON) && (cnt_q == '0);

  assign ton_ext     = CNT_W'(ton_cyc);
  assign ton_clamped = (ton_ext < MIN_ON_V) ? MIN_ON_V : ton_ext;

  cot_fire_qual u_qual (
    .run      (run),
    .cmp_hit  (cmp_hit),
    .oc_hit   (oc_hit),
    .off_done (off_done),
    .state    (st_q),
    .fire     (fire)
  );

  cot_off_timer #(
    .W    (OFF_W),
    .LOAD (MIN_OFF_CYC - 1)
  ) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .start (off_start),
    .done  (off_done)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    len_d = len_q;
    if (!run) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_LOW: begin
          if (fire) begin
            st_d  = ST_LEAD;
            cnt_d = DT_LOAD;
            len_d = ton_clamped;
          end else if (st_q == ST_LOW && zc_cut) begin
            st_d = ST_IDLE;
          end
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            st_d  = ST_ON;
            cnt_d = len_q - 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_ON: begin
          if (cnt_q == '0) begin
            st_d  = ST_TAIL;
            cnt_d = DT_LOAD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_TAIL: begin
          if (zc_cut) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (cnt_q == '0) begin
            st_d = ST_LOW;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= MIN_ON_V;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  cot_gate_drive u_drv (
    .run    (run),
    .state  (st_q),
    .skip   (mode_skip),
    .oc_hit (oc_hit),
    .zc_hit (zc_hit),
    .hs_en  (hs_en),
    .ls_en  (ls_en)
  );
endmodule

// File: rtl/cot_gate_seq_chk.sv
`timescale 1ns/1ps
module cot_gate_seq_chk #(
  parameter int unsigned DT      = 3,
  parameter int unsigned MIN_ON  = 11,
  parameter int unsigned MIN_OFF = 30
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic force_off,
  input logic mode_skip,
  input logic oc_hit,
  input logic zc_hit,
  input logic hs_en,
  input logic ls_en
);
  logic        run;
  logic [15:0] hi_run, lo_run;
  logic        seen_q;

  assign run = en && !force_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      seen_q <= 1'b0;
    end else begin
      hi_run <= hs_en ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= hs_en ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
      if (!run)       seen_q <= 1'b0;
      else if (hs_en) seen_q <= 1'b1;
    end
  end

  // R9
  shutdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!hs_en && !ls_en));

  // R8
  oc_blocks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_hit |-> !ls_en);

  // R7
  zc_cuts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_skip && zc_hit) |-> !ls_en);

  // R5
  hs_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(ls_en));

  // R5
  ls_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_en));

  // R3
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_en) && run) |-> (hi_run >= 16'(MIN_ON)));

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en) && seen_q) |-> (lo_run >= 16'(MIN_OFF + DT)));
endmodule

bind cot_gate_seq cot_gate_seq_chk #(
  .DT      (DT_CYC),
  .MIN_ON  (MIN_ON_CYC),
  .MIN_OFF (MIN_OFF_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .force_off (force_off),
  .mode_skip (mode_skip),
  .oc_hit    (oc_hit),
  .zc_hit    (zc_hit),
  .hs_en     (hs_en),
  .ls_en     (ls_en)
);

// File: tb/cot_gate_seq_bench.sv
`timescale 1ns/1ps
module cot_gate_seq_bench;
  localparam int TON_W  = 8;
  localparam int CLK_NS = 10;
  localparam int DT     = (30 + CLK_NS - 1) / CLK_NS;
  localparam int MINON  = (110 + CLK_NS - 1) / CLK_NS;
  localparam int MINOFF = (300 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n, en, force_off, mode_skip, cmp_hit, oc_hit, zc_hit;
  logic [TON_W-1:0] ton_cyc;
  logic hs_en, ls_en;

  always #5 clk = ~clk;

  cot_gate_seq #(.CLK_NS(CLK_NS), .TON_W(TON_W)) u_cot_gate_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .force_off(force_off),
    .mode_skip(mode_skip), .cmp_hit(cmp_hit), .oc_hit(oc_hit),
    .zc_hit(zc_hit), .ton_cyc(ton_cyc), .hs_en(hs_en), .ls_en(ls_en)
  );

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_width(int t);
    return (t < MINON) ? MINON : t;
  endfunction

  // input history sampled at each rising edge
  bit cmp_h [0:DT];
  bit oc_h  [0:DT];
  bit zc_h  [0:DT];
  bit hs_h  [0:DT];
  bit sk_h  [0:DT];
  int ton_h [0:DT];

  always @(posedge clk) begin
    for (int i = DT; i > 0; i--) begin
      cmp_h[i] <= cmp_h[i-1]; oc_h[i] <= oc_h[i-1]; zc_h[i] <= zc_h[i-1];
      hs_h[i] <= hs_h[i-1]; sk_h[i] <= sk_h[i-1]; ton_h[i] <= ton_h[i-1];
    end
    cmp_h[0] <= cmp_hit; oc_h[0] <= oc_hit; zc_h[0] <= zc_hit;
    hs_h[0] <= hs_en; sk_h[0] <= mode_skip; ton_h[0] <= int'(ton_cyc);
  end

  // monitor state
  bit hs_p = 0, ls_p = 0, ever = 0, ready = 0, kill = 0;
  bit dirt_fall = 1, dirt_pulse = 1, mon_on = 0;
  int hs_lo = 0, ls_lo = 0, hi_cnt = 0, want_w = 0;

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      bit run_now;
      int hl_old;
      run_now = en && !force_off;
      ready = ready && cmp_h[0] && !oc_h[0];
      if (sk_h[0] && zc_h[0] && !hs_h[0]) kill = 1;
      if (!run_now) begin dirt_fall = 1; dirt_pulse = 1; ready = 0; end
      hl_old = hs_lo;
      hs_lo = hs_en ? 0 : hs_lo + 1;
      ls_lo = ls_en ? 0 : ls_lo + 1;

      if (hs_en && ls_en) chk(0, "R5 overlap", 1, 0);
      if (!run_now) chk(!hs_en && !ls_en, "R9 shutdown", {hs_en, ls_en}, 0);
      if (oc_hit) chk(!ls_en, "R8 oc low-side", ls_en, 0);
      if (mode_skip && zc_hit) chk(!ls_en, "R7 zc low-side", ls_en, 0);
      if (kill && !hs_en) chk(!ls_en, "R7 rest after zc", ls_en, 0);

      if (hs_en && !hs_p) begin
        chk(cmp_h[DT] && !oc_h[DT], "R2/R8 trigger qualify", {cmp_h[DT], oc_h[DT]}, 2);
        chk(ls_lo >= DT + 1, "R5 dead before high", ls_lo, DT + 1);
        if (ever && !dirt_fall) begin
          chk(hl_old >= MINOFF + DT, "R4 min gap", hl_old, MINOFF + DT);
          if (ready) chk(hl_old == MINOFF + DT, "R4 exact gap", hl_old, MINOFF + DT);
        end
        want_w = exp_width(ton_h[DT]);
        hi_cnt = 0; dirt_pulse = 0; kill = 0;
      end
      if (hs_en) hi_cnt++;
      if (!hs_en && hs_p) begin
        if (!dirt_pulse) chk(hi_cnt == want_w, "R3 width", hi_cnt, want_w);
        dirt_fall = !run_now; ever = 1; ready = 1; kill = 0;
      end
      if (ls_en && !ls_p) chk(hs_lo >= DT + 1, "R5 dead before low", hs_lo, DT + 1);
      if (!hs_en && hs_lo == DT + 1 && ever && !dirt_fall && run_now && !oc_hit
          && !kill && !(mode_skip && zc_hit))
        chk(ls_en, "R6/R7 low-side on after dead-time", ls_en, 1);
      hs_p = hs_en; ls_p = ls_en;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int hs_seen;
    void'($urandom(32'd4711));
    rst_n = 0; en = 1; force_off = 0; mode_skip = 0;
    cmp_hit = 0; oc_hit = 0; zc_hit = 0; ton_cyc = 8'd20;
    tick(5);
    chk(!hs_en && !ls_en, "R1 in reset", {hs_en, ls_en}, 0);
    rst_n = 1; mon_on = 1;
    tick(10);
    chk(!hs_en && !ls_en, "R1 after reset", {hs_en, ls_en}, 0);

    // R6: forced PWM ignores zero crossing
    cmp_hit = 1; tick(1); cmp_hit = 0; zc_hit = 1;
    tick(80);
    chk(ls_en == 1, "R6 zc ignored", ls_en, 1);
    zc_hit = 0;

    // R3: minimum width and zero on-time
    ton_cyc = 8'd4; cmp_hit = 1; tick(1); cmp_hit = 0; tick(60);
    ton_cyc = 8'd0; cmp_hit = 1; tick(1); cmp_hit = 0; tick(60);
    // R3: on-time change mid-pulse ignored
    ton_cyc = 8'd40; cmp_hit = 1; tick(1); cmp_hit = 0; tick(DT + 4);
    chk(hs_en == 1, "R3 pulse running", hs_en, 1);
    ton_cyc = 8'd2; tick(90);

    // R4: back-to-back pulses with trigger held
    ton_cyc = 8'd12; cmp_hit = 1; tick(250); cmp_hit = 0; tick(40);

    // R7: switch to pulse skipping inside a force window
    force_off = 1; tick(1); mode_skip = 1; force_off = 0; tick(2);
    cmp_hit = 1; tick(1); cmp_hit = 0; tick(30);
    chk(ls_en == 1, "R7 low on before zc", ls_en, 1);
    zc_hit = 1; @(negedge clk);
    chk(ls_en == 0, "R7 cut at zc", ls_en, 0);
    tick(1); zc_hit = 0; tick(20);
    chk(!ls_en && !hs_en, "R7 rest after zc", {hs_en, ls_en}, 0);

    // R8: over-current blocks trigger and low side
    oc_hit = 1; cmp_hit = 1; hs_seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (hs_en || ls_en) hs_seen++;
    end
    chk(hs_seen == 0, "R8 blocked under oc", hs_seen, 0);
    tick(1); oc_hit = 0; tick(1); cmp_hit = 0; tick(60);

    // R9: force mid-pulse
    cmp_hit = 1; tick(1); cmp_hit = 0; tick(DT + 3);
    chk(hs_en == 1, "R9 pulse before force", hs_en, 1);
    force_off = 1; @(negedge clk);
    chk(!hs_en && !ls_en, "R9 force same cycle", {hs_en, ls_en}, 0);
    tick(1); force_off = 0; tick(40);
    chk(!hs_en && !ls_en, "R9 idle after force", {hs_en, ls_en}, 0);

    // R9: enable low mid-pulse, back in forced PWM
    force_off = 1; tick(1); mode_skip = 0; force_off = 0; tick(1);
    cmp_hit = 1; tick(1); cmp_hit = 0; tick(DT + 2);
    en = 0; @(negedge clk);
    chk(!hs_en && !ls_en, "R9 disable same cycle", {hs_en, ls_en}, 0);
    tick(1); en = 1; tick(30);
    chk(!hs_en && !ls_en, "R9 idle after disable", {hs_en, ls_en}, 0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom % 100 < 2) begin
        force_off = 1; tick(1);
        mode_skip = $urandom % 2;
        force_off = 0;
      end
      en      = ($urandom % 200) != 0;
      cmp_hit = ($urandom % 100) < 40;
      oc_hit  = ($urandom % 100) < 8;
      zc_hit  = ($urandom % 100) < 15;
      if ($urandom % 8 == 0) ton_cyc = 8'($urandom % 64);
      tick(1);
    end
    en = 1; cmp_hit = 0; oc_hit = 0; zc_hit = 0;
    tick(60);
    finish_run();
  end
endmodule